// File: doc/BRIEF.md
# Interval-Based Operating-Point Selector

The block watches one core event signal per cycle and sorts every cycle into one of two kinds. A cycle is either frequency-scalable steady-state work or memory-bound time spent waiting on a long-latency last-level cache miss. A miss interval opens when such a miss stalls the core and closes once the pipeline is back in steady state. Two saturating counters add up the cycles of each kind over a programmable epoch. At the epoch boundary both counts are latched and the counters are cleared in the same cycle.

After each epoch boundary a sequential evaluator visits the four entries of a frequency/power table, one entry per cycle. For each entry it predicts the execution time: the steady cycles are scaled by the ratio of the current frequency to the candidate frequency, and the miss cycles keep their wall-time length. From that time it forms an energy-delay metric and keeps the best entry under the selected policy. When the last entry has been compared, the winning index appears on the output together with a one-cycle done pulse. The frequency of that winning point then serves as the current frequency for the next epoch.

Top module: `ivds_sel`

## Requirements
- R1: With `mode_refined`=0, a cycle counts as miss time when `win_blocked`=1 and as steady time otherwise; `mshr_occ` has no effect on the counts.
- R2: With `mode_refined`=1, a cycle counts as miss time when `mshr_occ` is non-zero and as steady time otherwise; `win_blocked` has no effect on the counts.
- R3: Each epoch lasts `epoch_len` counted cycles. On the last cycle of an epoch, the counts including that cycle's event are copied to `obs_steady`/`obs_miss`, and both counters restart from zero on the next cycle, so that no cycle is lost.
- R4: Both counters saturate at 2^CNT_W-1 instead of wrapping.
- R5: The predicted time of point i is floor(steady × f_cur / f_i) + miss, where f_i is table entry i (entry 0 in the low bits, frequencies ascending with the index).
- R6: `policy`=0 chooses the point with the smallest P_i × t_i².
- R7: `policy`=1 or 3 chooses the point with the smallest P_i × t_i³.
- R8: `policy`=2 chooses the smallest P_i × t_i³ among the points whose time satisfies t_i × 256 ≤ t_3 × (256 + `loss_bound`); point 3 is always eligible.
- R9: When two points have equal metrics, the one with the lower index (lower frequency) wins.
- R10: `done` is a one-cycle pulse raised 4 cycles after the epoch's last cycle, and `sel_idx` changes only in a cycle where `done` is high.
- R11: A synchronous active-high `rst` clears the counters, the epoch timer and `done`, and sets `sel_idx` to 3.
- R12: f_cur is the frequency of the point that `sel_idx` shows at the epoch's last cycle; `policy` and `loss_bound` are sampled in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_refined | input | 1 | 0: window-blocked rule, 1: miss-register occupancy rule |
| win_blocked | input | 1 | Instruction window blocked by an outstanding miss |
| mshr_occ | input | OCC_W | Number of busy miss-handling registers |
| policy | input | 2 | 0 EDP, 1/3 ED2P, 2 bounded ED2P |
| loss_bound | input | 8 | Allowed slowdown in 1/256 units for policy 2 |
| epoch_len | input | EP_W | Epoch length in cycles (at least 8) |
| sel_idx | output | 2 | Selected operating point |
| done | output | 1 | Selection finished (one-cycle pulse) |
| obs_steady | output | CNT_W | Steady cycles latched from the last epoch |
| obs_miss | output | CNT_W | Miss cycles latched from the last epoch |

## Verification
Two functions can land on the same clock edge. The first case is the epoch boundary together with the counting of that cycle's own event. The second is the boundary together with a counter that has already saturated. The bench covers the first on every epoch, and it forces the second by stretching one epoch to 300 all-steady cycles on an 8-bit counter, so the saturated count meets the latch. A behavioural model predicts the latched counts and the selected point, and the bench compares them with the outputs on every cycle, so a lost or doubly counted boundary cycle shows up as a count that is off by one.

// File: rtl/ivds_pkg.sv
package ivds_pkg;
  localparam int NPTS  = 4;
  localparam int IDX_W = 2;
  localparam int BND_W = 8;

  typedef enum logic [1:0] {
    POL_EDP      = 2'd0,
    POL_ED2P     = 2'd1,
    POL_ED2P_LIM = 2'd2,
    POL_ED2P_ALT = 2'd3
  } pol_e;
endpackage

// File: rtl/ivds_satcnt.sv
module ivds_satcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q,
  output logic [W-1:0] nxt
);
  always_comb begin
    if (inc && (q != {W{1'b1}})) nxt = q + W'(1);
    else                         nxt = q;
  end

  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (clr) q <= '0;
    else          q <= nxt;
  end
endmodule

// File: rtl/ivds_classify.sv
module ivds_classify #(
  parameter int CNT_W = 20,
  parameter int EP_W  = 20,
  parameter int OCC_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_refined,
  input  logic             win_blocked,
  input  logic [OCC_W-1:0] mshr_occ,
  input  logic [EP_W-1:0]  epoch_len,
  output logic             ev_miss,
  output logic             epoch_end,
  output logic [CNT_W-1:0] steady_cnt,
  output logic [CNT_W-1:0] miss_cnt,
  output logic [CNT_W-1:0] steady_nxt,
  output logic [CNT_W-1:0] miss_nxt
);
  logic [EP_W-1:0] ep_cnt;
  logic [1:0][CNT_W-1:0] cnt_q;
  logic [1:0][CNT_W-1:0] cnt_n;

  assign ev_miss   = mode_refined ? (mshr_occ != '0) : win_blocked;
  assign epoch_end = (({1'b0, ep_cnt} + (EP_W+1)'(1)) >= {1'b0, epoch_len});

  always_ff @(posedge clk) begin
    if (rst)            ep_cnt <= '0;
    else if (epoch_end) ep_cnt <= '0;
    else                ep_cnt <= ep_cnt + EP_W'(1);
  end

  // slot 0 counts steady cycles, slot 1 counts miss cycles
  for (genvar k = 0; k < 2; k++) begin : g_cnt
    ivds_satcnt #(.W(CNT_W)) u_cnt (
      .clk (clk),
      .rst (rst),
      .clr (epoch_end),
      .inc ((k == 1) ? ev_miss : ~ev_miss),
      .q   (cnt_q[k]),
      .nxt (cnt_n[k])
    );
  end

  assign steady_cnt = cnt_q[0];
  assign miss_cnt   = cnt_q[1];
  assign steady_nxt = cnt_n[0];
  assign miss_nxt   = cnt_n[1];
endmodule

// File: rtl/ivds_eval.sv
module ivds_eval
  import ivds_pkg::*;
#(
  parameter int CNT_W   = 20,
  parameter int RATIO_W = 8,
  parameter int PWR_W   = 8,
  parameter logic [NPTS*RATIO_W-1:0] FREQ_TAB  = {8'd16, 8'd12, 8'd10, 8'd8},
  parameter logic [NPTS*PWR_W-1:0]   POWER_TAB = {8'd64, 8'd40, 8'd25, 8'd16}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] cnt_steady,
  input  logic [CNT_W-1:0] cnt_miss,
  input  logic [1:0]       policy,
  input  logic [BND_W-1:0] loss_bound,
  output logic [IDX_W-1:0] sel_idx,
  output logic             done,
  output logic             busy,
  output logic [CNT_W-1:0] obs_steady,
  output logic [CNT_W-1:0] obs_miss
);
  localparam int T_W   = CNT_W + RATIO_W + 1;
  localparam int MET_W = 3 * T_W + PWR_W;
  localparam int CMP_W = T_W + 9;
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NPTS - 1);

  function automatic logic [RATIO_W-1:0] freq_at(input logic [IDX_W-1:0] i);
    return FREQ_TAB[i*RATIO_W +: RATIO_W];
  endfunction

  function automatic logic [PWR_W-1:0] pwr_at(input logic [IDX_W-1:0] i);
    return POWER_TAB[i*PWR_W +: PWR_W];
  endfunction

  // R5: scaled steady time plus unscaled miss time
  function automatic logic [T_W-1:0] pred_time(
    input logic [CNT_W-1:0]   s,
    input logic [CNT_W-1:0]   m,
    input logic [RATIO_W-1:0] fc,
    input logic [RATIO_W-1:0] fi
  );
    logic [T_W-1:0] num;
    num = T_W'(s) * T_W'(fc);
    return (num / T_W'(fi)) + T_W'(m);
  endfunction

  function automatic logic [MET_W-1:0] pred_metric(
    input logic [T_W-1:0]   t,
    input logic [PWR_W-1:0] p,
    input logic             cube
  );
    logic [MET_W-1:0] acc;
    acc = MET_W'(t) * MET_W'(t);
    if (cube) acc = acc * MET_W'(t);
    return acc * MET_W'(p);
  endfunction

  logic [CNT_W-1:0]   l_steady, l_miss;
  logic [RATIO_W-1:0] l_fcur;
  pol_e               l_pol;
  logic [BND_W-1:0]   l_bnd;
  logic [IDX_W-1:0]   step, best_idx;
  logic [MET_W-1:0]   best_m;
  logic [T_W-1:0]     t_top;

  logic [T_W-1:0]   cur_t;
  logic [MET_W-1:0] cur_m;
  logic             over, acc;

  always_comb begin
    cur_t = pred_time(l_steady, l_miss, l_fcur, freq_at(step));
    cur_m = pred_metric(cur_t, pwr_at(step), l_pol != POL_EDP);
    over  = (l_pol == POL_ED2P_LIM) &&
            ((CMP_W'(cur_t) << 8) > (CMP_W'(t_top) * CMP_W'({1'b0, l_bnd} + 9'd256)));
    acc   = (step == TOP_IDX) || (!over && (cur_m <= best_m));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      done       <= 1'b0;
      step       <= '0;
      sel_idx    <= TOP_IDX;
      best_idx   <= TOP_IDX;
      best_m     <= '0;
      t_top      <= '0;
      l_steady   <= '0;
      l_miss     <= '0;
      l_fcur     <= '0;
      l_pol      <= POL_EDP;
      l_bnd      <= '0;
      obs_steady <= '0;
      obs_miss   <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        l_steady   <= cnt_steady;
        l_miss     <= cnt_miss;
        obs_steady <= cnt_steady;
        obs_miss   <= cnt_miss;
        l_fcur     <= freq_at(sel_idx);
        l_pol      <= pol_e'(policy);
        l_bnd      <= loss_bound;
        busy       <= 1'b1;
        step       <= TOP_IDX;
      end else if (busy) begin
        if (acc) begin
          best_idx <= step;
          best_m   <= cur_m;
        end
        if (step == TOP_IDX) t_top <= cur_t;
        if (step == '0) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          sel_idx <= acc ? '0 : best_idx;
        end else begin
          step <= step - IDX_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/ivds_sel.sv
module ivds_sel
  import ivds_pkg::*;
#(
  parameter int CNT_W   = 20,
  parameter int EP_W    = 20,
  parameter int OCC_W   = 4,
  parameter int RATIO_W = 8,
  parameter int PWR_W   = 8,
  parameter logic [NPTS*RATIO_W-1:0] FREQ_TAB  = {8'd16, 8'd12, 8'd10, 8'd8},
  parameter logic [NPTS*PWR_W-1:0]   POWER_TAB = {8'd64, 8'd40, 8'd25, 8'd16}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_refined,
  input  logic             win_blocked,
  input  logic [OCC_W-1:0] mshr_occ,
  input  logic [1:0]       policy,
  input  logic [7:0]       loss_bound,
  input  logic [EP_W-1:0]  epoch_len,
  output logic [1:0]       sel_idx,
  output logic             done,
  output logic [CNT_W-1:0] obs_steady,
  output logic [CNT_W-1:0] obs_miss
);
  logic             ev_miss;
  logic             epoch_end;
  logic             busy;
  logic [CNT_W-1:0] steady_cnt, miss_cnt;
  logic [CNT_W-1:0] steady_nxt, miss_nxt;

  ivds_classify #(.CNT_W(CNT_W), .EP_W(EP_W), .OCC_W(OCC_W)) u_cls (
    .clk          (clk),
    .rst          (rst),
    .mode_refined (mode_refined),
    .win_blocked  (win_blocked),
    .mshr_occ     (mshr_occ),
    .epoch_len    (epoch_len),
    .ev_miss      (ev_miss),
    .epoch_end    (epoch_end),
    .steady_cnt   (steady_cnt),
    .miss_cnt     (miss_cnt),
    .steady_nxt   (steady_nxt),
    .miss_nxt     (miss_nxt)
  );

  ivds_eval #(
    .CNT_W(CNT_W), .RATIO_W(RATIO_W), .PWR_W(PWR_W),
    .FREQ_TAB(FREQ_TAB), .POWER_TAB(POWER_TAB)
  ) u_eval (
    .clk        (clk),
    .rst        (rst),
    .start      (epoch_end),
    .cnt_steady (steady_nxt),
    .cnt_miss   (miss_nxt),
    .policy     (policy),
    .loss_bound (loss_bound),
    .sel_idx    (sel_idx),
    .done       (done),
    .busy       (busy),
    .obs_steady (obs_steady),
    .obs_miss   (obs_miss)
  );
endmodule

// File: rtl/ivds_chk.sv
module ivds_chk #(
  parameter int CNT_W = 20
) (
  input logic             clk,
  input logic             rst,
  input logic             ev_miss,
  input logic             epoch_end,
  input logic             busy,
  input logic             done,
  input logic [1:0]       sel_idx,
  input logic [CNT_W-1:0] steady_cnt,
  input logic [CNT_W-1:0] miss_cnt
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
  logic [CNT_W:0] tot;
  assign tot = {1'b0, steady_cnt} + {1'b0, miss_cnt};

  // R4
  sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (steady_cnt == CMAX && !epoch_end) |=> steady_cnt == CMAX);

  // R3
  epoch_clear_chk: assert property (@(posedge clk) disable iff (rst)
    epoch_end |=> (steady_cnt == '0 && miss_cnt == '0));

  // R1
  one_kind_chk: assert property (@(posedge clk) disable iff (rst)
    (!epoch_end && steady_cnt != CMAX && miss_cnt != CMAX)
      |=> tot == $past(tot) + (CNT_W+1)'(1));

  // R2
  miss_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_miss && !epoch_end && miss_cnt != CMAX) |=> miss_cnt == $past(miss_cnt) + CNT_W'(1));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sel_idx) |-> done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

bind ivds_sel ivds_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ev_miss    (ev_miss),
  .epoch_end  (epoch_end),
  .busy       (busy),
  .done       (done),
  .sel_idx    (sel_idx),
  .steady_cnt (steady_cnt),
  .miss_cnt   (miss_cnt)
);

// File: tb/tb_ivds_sel.sv
`timescale 1ns/1ps
module tb_ivds_sel;
  localparam int CNT_W = 8;
  localparam int EP_W  = 12;
  localparam int OCC_W = 3;
  localparam int CMAXI = 255;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             mode_refined = 1'b0;
  logic             win_blocked = 1'b0;
  logic [OCC_W-1:0] mshr_occ = '0;
  logic [1:0]       policy = 2'd0;
  logic [7:0]       loss_bound = 8'd0;
  logic [EP_W-1:0]  epoch_len = EP_W'(40);
  logic [1:0]       sel_idx;
  logic             done;
  logic [CNT_W-1:0] obs_steady, obs_miss;

  always #4 clk = ~clk;

  ivds_sel #(
    .CNT_W(CNT_W), .EP_W(EP_W), .OCC_W(OCC_W),
    .FREQ_TAB({8'd16, 8'd12, 8'd10, 8'd8}),
    .POWER_TAB({8'd64, 8'd36, 8'd16, 8'd16})
  ) dut (
    .clk(clk), .rst(rst), .mode_refined(mode_refined), .win_blocked(win_blocked),
    .mshr_occ(mshr_occ), .policy(policy), .loss_bound(loss_bound), .epoch_len(epoch_len),
    .sel_idx(sel_idx), .done(done), .obs_steady(obs_steady), .obs_miss(obs_miss)
  );

  int tests = 0;
  int fails = 0;
  int freq_t[4] = '{8, 10, 12, 16};
  int pwr_t[4]  = '{16, 16, 36, 64};

  // reference state
  int m_st, m_ms, m_ep, m_sel, m_cd, m_pend, m_pol, m_os, m_om;
  bit m_done;

  // R5 time, R6/R7 metric, R8 bound, R9 ties, R12 current frequency
  function automatic int pick(int s, int m, int fc, int pol, int bnd);
    longint t[4];
    longint best_m, mm;
    int best;
    foreach (t[i]) t[i] = longint'((s * fc) / freq_t[i] + m);
    best = 3;
    best_m = (pol == 0) ? pwr_t[3] * t[3] * t[3] : pwr_t[3] * t[3] * t[3] * t[3];
    for (int i = 2; i >= 0; i--) begin
      if (pol == 2 && t[i] * 256 > t[3] * (256 + bnd)) continue;
      mm = (pol == 0) ? pwr_t[i] * t[i] * t[i] : pwr_t[i] * t[i] * t[i] * t[i];
      if (mm <= best_m) begin best = i; best_m = mm; end
    end
    return best;
  endfunction

  always @(posedge clk) begin
    int ns, nm;
    bit ev;
    if (rst) begin
      m_st = 0; m_ms = 0; m_ep = 0; m_sel = 3; m_cd = 0; m_done = 0;
      m_os = 0; m_om = 0; m_pend = 3; m_pol = 0;
    end else begin
      m_done = 0;
      if (m_cd > 0) begin
        m_cd--;
        if (m_cd == 0) begin m_sel = m_pend; m_done = 1; end
      end
      ev = mode_refined ? (mshr_occ != 0) : win_blocked;
      ns = (!ev && m_st < CMAXI) ? m_st + 1 : m_st;
      nm = ( ev && m_ms < CMAXI) ? m_ms + 1 : m_ms;
      if (m_ep + 1 >= int'(epoch_len)) begin
        m_os = ns; m_om = nm; m_pol = policy;
        m_pend = pick(ns, nm, freq_t[m_sel], int'(policy), int'(loss_bound));
        m_cd = 4;
        m_st = 0; m_ms = 0; m_ep = 0;
      end else begin
        m_st = ns; m_ms = nm; m_ep++;
      end
    end
  end

  always @(negedge clk) begin
    string tag;
    if (!rst) begin
      tag = !m_done ? "R10" : (m_pol == 0) ? "R6" : (m_pol == 2) ? "R8" : "R7";
      tests++;
      if (sel_idx != 2'(m_sel) || done != m_done) begin
        fails++;
        $display("FAIL %s sel/done: actual %0d/%0b expected %0d/%0b", tag, sel_idx, done, m_sel, m_done);
      end
      tests++;
      if (int'(obs_steady) != m_os || int'(obs_miss) != m_om) begin
        fails++;
        $display("FAIL R1 R2 R3 R4 latched counts: actual %0d/%0d expected %0d/%0d",
                 obs_steady, obs_miss, m_os, m_om);
      end
    end
  end

  task automatic run(input bit md, input int pol, input int bnd, input int len,
                     input int pblk, input int pocc, input int n);
    repeat (n) begin
      @(negedge clk);
      mode_refined = md;
      policy = 2'(pol);
      loss_bound = 8'(bnd);
      epoch_len = EP_W'(len);
      win_blocked = (($urandom % 100) < pblk);
      mshr_occ = (($urandom % 100) < pocc) ? OCC_W'(1 + ($urandom % 7)) : '0;
    end
  endtask

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 sel", int'(sel_idx), 3);
    check("R11 done", int'(done), 0);
    rst = 1'b0;
    run(0, 0, 0, 40, 0, 80, 100);    // R1: occupancy ignored in basic mode
    run(0, 1, 0, 40, 50, 10, 100);   // R7
    run(1, 0, 0, 40, 30, 70, 100);   // R2: window flag ignored in refined mode
    run(1, 2, 0, 40, 50, 20, 100);   // R8 tight bound
    run(1, 2, 64, 40, 50, 20, 100);  // R8 loose bound
    run(0, 3, 0, 33, 20, 50, 100);   // R7 alternate code
    run(0, 0, 0, 40, 100, 0, 120);   // R9 all-miss tie
    check("R9 tie to lower point", int'(sel_idx), 0);
    run(1, 1, 0, 300, 0, 0, 700);    // R4 saturation meets epoch end
    check("R4 saturated steady", int'(obs_steady), 255);
    check("R4 miss zero", int'(obs_miss), 0);
    run(0, 0, 0, 40, 5, 0, 100);     // R12 frequency reference moves
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule